// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions on the two-wire serial bus that configures Ethernet PHYs. A host presents one command: a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the MDC clock and drives or releases the MDIO line for the whole frame. It raises `busy` while the frame runs. At the end it pulses `done` for one cycle. After a read, the 16-bit result is on `rd_data`.

The MDIO pad is split into `mdio_o`, `mdio_oe` and `mdio_i`, so the tristate buffer sits outside the block. Each frame opens with an extended preamble of all ones. Both reads and writes end with one extra MDC pulse while MDIO is released. The `half_div` input sets the length of every MDC phase in system-clock cycles. The host picks it so that each phase lasts at least about 1 µs.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy` and `done` are all 0.
- R2: A frame begins with 40 MDC pulses. During each of them `mdio_oe` is 1 and `mdio_o` is 1.
- R3: Pulses 40 and 41 carry the start bits 0 then 1. Pulses 42 and 43 carry the opcode: 1,0 for a read (`cmd_read`=1) and 0,1 for a write.
- R4: Pulses 44 to 48 carry `cmd_phy`, and pulses 49 to 53 carry `cmd_reg`, each MSB first and driven.
- R5: Each MDC low phase and each high phase lasts exactly `half_div`+1 clock cycles. `mdio_o` and `mdio_oe` change only while MDC is low.
- R6: On a read, `mdio_oe` is 0 from pulse 54 (turnaround) to the end of the frame. `mdio_i` passes through a two-flop synchroniser. One bit is shifted into `rd_data` MSB first at the end of each of pulses 55 to 70.
- R7: A read frame has exactly 72 MDC pulses and a write frame has exactly 73.
- R8: On a write, pulses 54 and 55 drive the turnaround 1 then 0. Pulses 56 to 71 then drive `cmd_wdata`, MSB first.
- R9: The last pulse of every frame has `mdio_oe`=0. `done` is high for exactly one cycle, when that pulse's high phase ends, and `busy` is 0 in that same cycle.
- R10: A `cmd_valid` that arrives while `busy` is 1 is ignored. The running frame is unchanged, and no second frame follows it.
- R11: A command presented in the cycle where `done` is 1 is accepted. `busy` is 1 in the following cycle, and a complete new frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when `busy` is 0 |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Data for a write |
| half_div | input | DIV_W | MDC phase length minus one, in clock cycles |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data collected by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pad input |

## Verification
Two events can fall in the same cycle: the end-of-frame `done` pulse and the acceptance of the next command. The bench watches for `done` after a write. In that same cycle it presents a read, with no idle gap. It then judges the overlap three ways: `busy` must be high in the next cycle, the new frame must have the correct 72 pulses and field contents, and every MDC phase must have the correct length. A frame that is accepted late lengthens the first low phase, and a frame that is lost never produces its pulses.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } mdc_phase_e;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int HDR_W  = 2 + 2 + ADDR_W + ADDR_W;      // start, op, phy, reg
    localparam int SHIFT_W = HDR_W + 2 + DATA_W;          // header, turnaround, data

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q >= limit);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {STAGES{RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              mdio_s,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int SLOT_W = $clog2(PRE_LEN + HDR_W + 2 + DATA_W + 2);
    localparam logic [SLOT_W-1:0] HDR_SLOT = SLOT_W'(PRE_LEN);
    localparam logic [SLOT_W-1:0] TA_SLOT  = SLOT_W'(PRE_LEN + HDR_W);
    localparam logic [SLOT_W-1:0] RD_FIRST = SLOT_W'(PRE_LEN + HDR_W + 1);
    localparam logic [SLOT_W-1:0] RD_LAST  = SLOT_W'(PRE_LEN + HDR_W + DATA_W);
    localparam logic [SLOT_W-1:0] RD_END   = SLOT_W'(PRE_LEN + HDR_W + DATA_W + 1);
    localparam logic [SLOT_W-1:0] WR_END   = SLOT_W'(PRE_LEN + HDR_W + 2 + DATA_W);

    typedef struct packed {
        logic               busy;
        logic               rd;
        mdc_phase_e         phase;
        logic [SLOT_W-1:0]  slot;
        logic [SHIFT_W-1:0] sh;
        logic [DATA_W-1:0]  rdata;
        logic               done;
    } frame_t;

    frame_t state_d, state_q;
    logic [SLOT_W-1:0] last_slot;

    assign last_slot = state_q.rd ? RD_END : WR_END;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (cmd_valid) begin
                state_d.busy  = 1'b1;
                state_d.rd    = cmd_read;
                state_d.phase = PH_LOW;
                state_d.slot  = '0;
                state_d.sh    = {START_PAT, (cmd_read ? OP_READ : OP_WRITE),
                                 cmd_phy, cmd_reg, TA_WRITE, cmd_wdata};
            end
        end else if (tick) begin
            if (state_q.phase == PH_LOW) begin
                state_d.phase = PH_HIGH;
            end else begin
                state_d.phase = PH_LOW;
                if (state_q.rd && (state_q.slot >= RD_FIRST) && (state_q.slot <= RD_LAST)) begin
                    state_d.rdata = {state_q.rdata[DATA_W-2:0], mdio_s};
                end
                if (state_q.slot >= HDR_SLOT) begin
                    state_d.sh = {state_q.sh[SHIFT_W-2:0], 1'b1};
                end
                if (state_q.slot == last_slot) begin
                    state_d.busy = 1'b0;
                    state_d.done = 1'b1;
                end else begin
                    state_d.slot = state_q.slot + SLOT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy    = state_q.busy;
    assign done    = state_q.done;
    assign rd_data = state_q.rdata;
    assign mdc     = state_q.busy && (state_q.phase == PH_HIGH);
    assign mdio_oe = state_q.busy &&
                     ((state_q.slot < TA_SLOT) || (!state_q.rd && (state_q.slot < WR_END)));
    assign mdio_o  = mdio_oe && ((state_q.slot < HDR_SLOT) || state_q.sh[SHIFT_W-1]);

    // R5
    high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |=> (!mdc || ($stable(mdio_o) && $stable(mdio_oe))));

    // R7
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state_q.slot <= last_slot));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    trail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && (state_q.slot == last_slot)) |-> !mdio_oe);

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(state_q.rd)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 40,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DIV_W-1:0]  half_div,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic tick;
    logic mdio_s;

    mdio_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .limit (half_div),
        .tick  (tick)
    );

    mdio_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mdio_i),
        .dout  (mdio_s)
    );

    mdio_frame #(.PRE_LEN(PRE_LEN)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .mdio_s    (mdio_s),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic [7:0]  half_div = 8'd2;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mdio_master i_mdio_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .half_div  (half_div),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY-side monitor and read responder
    logic        mdc_prev = 1'b0;
    int          idx = 0;
    int          len = 0;
    int          bad_len = 0;
    logic        rec_oe [0:79];
    logic        rec_d  [0:79];
    logic [15:0] rsp = '0;
    logic        rsp_rd = 1'b0;

    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            if (idx < 80) begin
                rec_oe[idx] = mdio_oe;
                rec_d[idx]  = mdio_o;
            end
            idx = idx + 1;
        end
        if (!mdc && mdc_prev) begin
            if (rsp_rd && (idx - 1) >= 54 && (idx - 1) <= 69)
                mdio_i = rsp[69 - (idx - 1)];
        end
        if (mdc != mdc_prev) begin
            if (len != int'(half_div) + 1) bad_len = bad_len + 1;
            len = 1;
            if (done) len = 0;
        end else if (!busy) begin
            len = 0;
        end else begin
            len = len + 1;
        end
        mdc_prev = mdc;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected {oe, data} for pulse k, from the requirement list
    function automatic logic [1:0] exp_slot(int k, logic rd, logic [4:0] pa, logic [4:0] ra,
                                            logic [15:0] wd);
        if (k < 40)  return 2'b11;
        if (k == 40) return 2'b10;
        if (k == 41) return 2'b11;
        if (k == 42) return {1'b1, rd};
        if (k == 43) return {1'b1, !rd};
        if (k < 49)  return {1'b1, pa[48 - k]};
        if (k < 54)  return {1'b1, ra[53 - k]};
        if (rd)      return 2'b00;
        if (k == 54) return 2'b11;
        if (k == 55) return 2'b10;
        if (k < 72)  return {1'b1, wd[71 - k]};
        return 2'b00;
    endfunction

    task automatic issue(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rv);
        #1;
        idx       = 0;
        bad_len   = 0;
        rsp       = rv;
        rsp_rd    = rd;
        cmd_valid = 1'b1;
        cmd_read  = rd;
        cmd_phy   = pa;
        cmd_reg   = ra;
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic judge_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                               input logic [15:0] wd, input logic [15:0] rv);
        int bad_pre = 0, bad_hdr = 0, bad_tail = 0;
        int n = rd ? 72 : 73;
        for (int k = 0; k < n && k < 80; k++) begin
            logic [1:0] e = exp_slot(k, rd, pa, ra, wd);
            logic       m = (rec_oe[k] !== e[1]) || (e[1] && rec_d[k] !== e[0]);
            if (m && k < 40) bad_pre++;
            else if (m && k < 54) bad_hdr++;
            else if (m) bad_tail++;
        end
        check(bad_pre == 0, "R2 preamble pulses", bad_pre, 0);
        check(bad_hdr == 0, "R3/R4 start, opcode, addresses", bad_hdr, 0);
        if (rd) check(bad_tail == 0, "R6 released after address", bad_tail, 0);
        else    check(bad_tail == 0, "R8 turnaround and write data", bad_tail, 0);
        check(idx == n, "R7 pulse count", idx, n);
        check(bad_len == 0, "R5 phase length", bad_len, 0);
        check((n > 80) || rec_oe[n-1] === 1'b0, "R9 last pulse released", rec_oe[n-1], 0);
        check(busy == 1'b0, "R9 busy low with done", busy, 0);
        if (rd) check(rd_data == rv, "R6 read data", rd_data, rv);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mdc == 1'b0,     "R1 mdc", mdc, 0);
        check(mdio_oe == 1'b0, "R1 mdio_oe", mdio_oe, 0);
        check(busy == 1'b0,    "R1 busy", busy, 0);
        check(done == 1'b0,    "R1 done", done, 0);
    endtask

    task automatic t_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rv, input logic [7:0] h);
        half_div = h;
        @(negedge clk);
        issue(rd, pa, ra, wd, rv);
        wait_done();
        judge_frame(rd, pa, ra, wd, rv);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", done, 0);
    endtask

    task automatic t_busy_ignore();
        half_div = 8'd2;
        @(negedge clk);
        issue(1'b0, 5'h0A, 5'h15, 16'hC3A5, 16'h0);
        repeat (200) @(negedge clk);
        #1;
        cmd_valid = 1'b1;
        cmd_read  = 1'b1;
        cmd_phy   = 5'h1F;
        cmd_reg   = 5'h1F;
        cmd_wdata = 16'h0000;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        judge_frame(1'b0, 5'h0A, 5'h15, 16'hC3A5, 16'h0);
        repeat (60) @(negedge clk);
        check(idx == 73, "R10 no extra frame after ignored command", idx, 73);
        check(busy == 1'b0, "R10 idle after ignored command", busy, 0);
    endtask

    task automatic t_back_to_back();
        half_div = 8'd3;
        @(negedge clk);
        issue(1'b0, 5'h11, 5'h02, 16'h5A5A, 16'h0);
        wait_done();
        judge_frame(1'b0, 5'h11, 5'h02, 16'h5A5A, 16'h0);
        issue(1'b1, 5'h06, 5'h19, 16'h0, 16'h7FFE);
        check(busy == 1'b1, "R11 command taken in done cycle", busy, 1);
        wait_done();
        judge_frame(1'b1, 5'h06, 5'h19, 16'h0, 16'h7FFE);
    endtask

    initial begin
        t_reset();
        t_frame(1'b1, 5'h15, 5'h0A, 16'h0, 16'hA5C3, 8'd2);
        t_frame(1'b0, 5'h1F, 5'h00, 16'h1234, 16'h0, 8'd1);
        t_frame(1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 8'd4);
        t_frame(1'b1, 5'h01, 5'h10, 16'h0, 16'h8001, 8'd1);
        t_busy_ignore();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule